// File: doc/BRIEF.md
# Selectable Link Test Pattern Generator

This block feeds a serial transmitter with one parallel word of test data per clock during a loopback test. A mode code picks one of four pseudo-random bit sequences (orders 7, 15, 23 and 31) or one of two square waves. The fast square wave toggles on every bit, which is half the line rate. The slow square wave holds each level for 33 bits. Every mode emits W bits per clock, and the bit that leaves first on the line sits in the most significant position of the word.

A run input starts and stops generation. While stopped, the generator state is frozen and a new mode code may be taken. While running, a one-cycle insert request flips a single bit of exactly one outgoing word. The receiver sees this as a known error. A saturating counter records how many words were corrupted, and a one-cycle clear pulse empties it.

Top module: `loopback_pattern_gen`

## Requirements
- R1: A synchronous active-low reset sets `tx_valid` to 0, `tx_data` to 0, `inj_count` to 0, and selects mode code 0 with every shift register loaded with all ones and every square-wave phase at 0.
- R2: Mode codes 0, 1, 2 and 3 give the sequences b(k) = b(k-n) xor b(k-t) with (n,t) = (7,6), (15,14), (23,18) and (31,28). Seen as bits, the last n bits before the first output are all ones. Each word carries the next W bits, and the earliest bit is in bit W-1.
- R3: Mode code 4 gives alternating bits. The first bit after a mode selection is 1, and the alternation carries across word boundaries when W is odd.
- R4: Mode code 5 gives 33 ones then 33 zeros, repeating. It starts with the first one after a mode selection, and the phase carries across word boundaries.
- R5: Each clock edge that samples `run` high produces one word, which is visible with `tx_valid` = 1 after that edge. An edge that samples `run` low drives `tx_valid` to 0, holds `tx_data`, and freezes the generator, so generation resumes where it stopped.
- R6: A mode code is taken only at an edge where `run` is low. Taking a code different from the current one reloads every generator to its start state (all ones, phase 0). Re-selecting the current code, giving a code of 6 or 7, or changing the code while running has no effect.
- R7: An insert pulse sampled with `run` high inverts bit 0 of the word produced at the next edge, and of that word only.
- R8: An insert pulse sampled with `run` low is ignored. A pending insert is discarded if `run` is low at the edge where it would be applied.
- R9: A second insert pulse sampled at the edge where a pending insert is applied is merged into it, so exactly one word is corrupted.
- R10: `inj_count` rises by one at each edge that outputs a corrupted word. It saturates at 2^CNT_W-1, while later insertions still corrupt their words.
- R11: A clear pulse sets `inj_count` to 0 at the next edge. It takes priority over an increment at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | MODE_W (3) | Pattern code, 0..5 |
| run | input | 1 | Generation enable |
| insert_req | input | 1 | One-cycle error insertion request |
| clear_req | input | 1 | One-cycle clear of the insertion counter |
| tx_data | output | W | Transmit word, earliest bit in the MSB |
| tx_valid | output | 1 | A new word was produced at the last edge |
| inj_count | output | CNT_W | Number of corrupted words, saturating |

## Verification
Every mode is swept for 150 words with an odd word width of 13. The bench compares each word against a bit-serial recurrence computed inside the bench. The odd width exposes phase errors at word boundaries in the square waves and wrong bit order in the shift registers. Stop/resume, re-selection of the same code, an invalid code and a code change while running are each told apart from a reload by the continuation of the expected sequence. Insert pulses are given singly, back to back, while stopped and just before a stop, so the position and count of flipped bits separate correct merging and discarding from double or lost insertions. A narrow counter is driven into saturation, and a clear is given together with an increment.

// File: rtl/tpg_pkg.sv
// Shared constants and types for the link test pattern generator.
// Assumes at most 8 mode codes; codes 6 and 7 are reserved and rejected.
package tpg_pkg;
    localparam int MODE_W    = 3;
    localparam int NUM_PRBS  = 4;
    localparam int NUM_MODES = 6;
    localparam int FAST_HALF = 1;   // half period in bits of the fast square wave
    localparam int SLOW_HALF = 33;  // half period in bits of the slow square wave

    typedef enum logic [MODE_W-1:0] {
        MODE_PRBS7  = 3'd0,
        MODE_PRBS15 = 3'd1,
        MODE_PRBS23 = 3'd2,
        MODE_PRBS31 = 3'd3,
        MODE_FAST   = 3'd4,
        MODE_SLOW   = 3'd5
    } mode_e;

    // Length of the shift register for pseudo-random generator idx.
    function automatic int prbs_order(input int idx);
        case (idx)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Second feedback tap (1-based) for pseudo-random generator idx.
    function automatic int prbs_tap(input int idx);
        case (idx)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction
endpackage

// File: rtl/tpg_lfsr.sv
// Multi-bit Fibonacci shift register for x^ORDER + x^TAP + 1.
// Produces W sequence bits per advance, with the earliest bit in word[W-1].
// Assumes TAP < ORDER. State bit i holds the bit emitted i+1 steps ago.
// reseed reloads all ones and takes priority over advance.
module tpg_lfsr #(
    parameter int ORDER = 7,
    parameter int TAP   = 6,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    output logic [W-1:0] word
);
    logic [ORDER-1:0] state_q;
    logic [ORDER-1:0] state_nxt;

    // Unroll W single-bit steps of the recurrence.
    always_comb begin
        logic [ORDER-1:0] s;
        logic             nb;
        s    = state_q;
        word = '0;
        for (int i = 0; i < W; i++) begin
            nb          = s[ORDER-1] ^ s[TAP-1];
            word[W-1-i] = nb;
            s           = {s[ORDER-2:0], nb};
        end
        state_nxt = s;
    end

    // Hold, reload or advance the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            state_q <= '1;
        end else if (advance) begin
            state_q <= state_nxt;
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0); // R2
endmodule

// File: rtl/tpg_square.sv
// Square wave of HALF ones then HALF zeros, W bits per advance.
// The earliest bit goes in word[W-1]. The phase counts bits within one
// period and carries across words, so it works for any W.
module tpg_square #(
    parameter int HALF = 33,
    parameter int W    = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reseed,
    input  logic         advance,
    output logic [W-1:0] word
);
    localparam int PERIOD = 2 * HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_nxt;

    // Build the word bit by bit from the running phase.
    always_comb begin
        int p;
        word = '0;
        for (int i = 0; i < W; i++) begin
            p           = (int'(phase_q) + i) % PERIOD;
            word[W-1-i] = (p < HALF);
        end
        phase_nxt = PH_W'((int'(phase_q) + W) % PERIOD);
    end

    // Hold, restart or advance the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= phase_nxt;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_q) < PERIOD); // R4
endmodule

// File: rtl/tpg_inject.sv
// Error insertion control and a saturating count of corrupted words.
// A request taken while running becomes pending. It is applied at the next
// running edge, and a request seen at that edge is merged into it. A stop
// discards a pending request. clear_req wins over an increment.
module tpg_inject #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             insert_req,
    input  logic             clear_req,
    output logic             apply,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic pending_q;

    assign apply = pending_q && run;

    // Track one outstanding insertion request.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pending_q <= 1'b0;
        end else if (pending_q) begin
            pending_q <= 1'b0;
        end else if (insert_req) begin
            pending_q <= 1'b1;
        end
    end

    // Count corrupted words, saturating, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_req) begin
            count <= '0;
        end else if (apply && count != CNT_MAX) begin
            count <= count + CNT_W'(1);
        end
    end

    AST_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> !apply); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_req |=> (count == $past(count) || count == $past(count) + CNT_W'(1))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clear_req) |=> count == CNT_MAX); // R10
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> count == '0); // R11
    AST_STOPPED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear_req) |=> $stable(count)); // R8
endmodule

// File: rtl/loopback_pattern_gen.sv
// Top of the selectable link test pattern generator.
// Holds the active mode, runs one generator per pattern, and registers the
// selected word with an optional bit-0 inversion. Assumes a synchronous
// active-low reset and inputs synchronous to clk.
module loopback_pattern_gen #(
    parameter int W     = 32,
    parameter int CNT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [tpg_pkg::MODE_W-1:0] mode_sel,
    input  logic                       run,
    input  logic                       insert_req,
    input  logic                       clear_req,
    output logic [W-1:0]               tx_data,
    output logic                       tx_valid,
    output logic [CNT_W-1:0]           inj_count
);
    import tpg_pkg::*;

    mode_e        mode_q;
    logic         reseed;
    logic         apply;
    logic [W-1:0] sel_word;
    logic [W-1:0] prbs_word [NUM_PRBS];
    logic [W-1:0] fast_word;
    logic [W-1:0] slow_word;

    // Accept a new, valid, different code only while stopped.
    assign reseed = !run && (int'(mode_sel) < NUM_MODES) && (mode_sel != mode_q);

    // Register the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PRBS7;
        end else if (reseed) begin
            mode_q <= mode_e'(mode_sel);
        end
    end

    for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
        tpg_lfsr #(
            .ORDER (prbs_order(g)),
            .TAP   (prbs_tap(g)),
            .W     (W)
        ) u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .reseed  (reseed),
            .advance (run && (int'(mode_q) == g)),
            .word    (prbs_word[g])
        );
    end

    tpg_square #(.HALF(FAST_HALF), .W(W)) u_fast (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .advance (run && mode_q == MODE_FAST),
        .word    (fast_word)
    );

    tpg_square #(.HALF(SLOW_HALF), .W(W)) u_slow (
        .clk     (clk),
        .rst_n   (rst_n),
        .reseed  (reseed),
        .advance (run && mode_q == MODE_SLOW),
        .word    (slow_word)
    );

    tpg_inject #(.CNT_W(CNT_W)) u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .insert_req (insert_req),
        .clear_req  (clear_req),
        .apply      (apply),
        .count      (inj_count)
    );

    // Pick the word of the active generator.
    always_comb begin
        case (mode_q)
            MODE_PRBS7:  sel_word = prbs_word[0];
            MODE_PRBS15: sel_word = prbs_word[1];
            MODE_PRBS23: sel_word = prbs_word[2];
            MODE_PRBS31: sel_word = prbs_word[3];
            MODE_FAST:   sel_word = fast_word;
            default:     sel_word = slow_word;
        endcase
    end

    // Register the output word, corrupting bit 0 when an insertion applies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= '0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= run;
            if (run) begin
                tx_data <= sel_word ^ {{(W-1){1'b0}}, apply};
            end
        end
    end

    AST_MODE_FROZEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(mode_q)); // R6
    AST_DATA_HELD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(tx_data)); // R5
endmodule

// File: tb/loopback_pattern_gen_tb.sv
// Bench: sweeps every mode against a bit-serial model and scripts the
// insertion, counter and mode-latch corner cases.
module loopback_pattern_gen_tb;
    localparam int W     = 13;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [2:0]       mode_sel;
    logic             run;
    logic             insert_req;
    logic             clear_req;
    logic [W-1:0]     tx_data;
    logic             tx_valid;
    logic [CNT_W-1:0] inj_count;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    logic [30:0] ms;
    int          mph;
    int          mmode;
    logic [W-1:0] held;

    always #10 clk = ~clk;  // 50 MHz

    loopback_pattern_gen #(.W(W), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .run        (run),
        .insert_req (insert_req),
        .clear_req  (clear_req),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .inj_count  (inj_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reseed();
        ms  = '1;
        mph = 0;
    endtask

    // Next word of the active mode, from the bit-level definitions.
    task automatic model_word(output logic [W-1:0] w);
        int  n;
        int  t;
        logic b;
        for (int i = 0; i < W; i++) begin
            case (mmode)
                0: begin n = 7;  t = 6;  end
                1: begin n = 15; t = 14; end
                2: begin n = 23; t = 18; end
                default: begin n = 31; t = 28; end
            endcase
            if (mmode < 4) begin
                b  = ms[n-1] ^ ms[t-1];
                ms = {ms[29:0], b};
            end else if (mmode == 4) begin
                b   = (mph == 0);
                mph = (mph + 1) % 2;
            end else begin
                b   = (mph < 33);
                mph = (mph + 1) % 66;
            end
            w[W-1-i] = b;
        end
    endtask

    // One clock: predict, advance, then check the outputs.
    task automatic tick(input logic flip, input string req);
        logic [W-1:0] e;
        logic         was_run;
        was_run = run;
        e = held;
        if (!run) begin
            if (int'(mode_sel) < 6 && int'(mode_sel) != mmode) begin
                mmode = int'(mode_sel);
                model_reseed();
            end
        end else begin
            model_word(e);
            e[0] = e[0] ^ flip;
        end
        @(posedge clk);
        @(negedge clk);
        if (was_run) begin
            check(tx_valid === 1'b1 && tx_data === e, req, longint'(tx_data), longint'(e));
            held = e;
        end else begin
            check(tx_valid === 1'b0 && tx_data === held, "R5 stopped", longint'(tx_data), longint'(held));
        end
    endtask

    task automatic chk_cnt(input int exp, input string req);
        check(int'(inj_count) == exp, req, longint'(inj_count), longint'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode_sel = 3'd0; run = 1'b0;
        insert_req = 1'b0; clear_req = 1'b0;
        mmode = 0; model_reseed(); held = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then PRBS7 from the all-ones start
        check(tx_valid === 1'b0, "R1 valid", longint'(tx_valid), 0);
        check(tx_data === '0, "R1 data", longint'(tx_data), 0);
        chk_cnt(0, "R1 count");
        run = 1'b1;
        for (int k = 0; k < 20; k++) tick(1'b0, "R1 default mode");

        // R2 R3 R4: sweep every mode
        for (int m = 0; m < 6; m++) begin
            run = 1'b0; mode_sel = 3'(m);
            tick(1'b0, "R6 select");
            run = 1'b1;
            for (int k = 0; k < 150; k++)
                tick(1'b0, (m < 4) ? "R2 prbs" : ((m == 4) ? "R3 fast" : "R4 slow"));
        end

        // R5: stop and resume continues the sequence
        run = 1'b0;
        for (int k = 0; k < 3; k++) tick(1'b0, "R5 stop");
        run = 1'b1;
        for (int k = 0; k < 10; k++) tick(1'b0, "R5 resume");

        // R6: same code again and reserved code leave the sequence running on
        run = 1'b0; mode_sel = 3'd5; tick(1'b0, "R6 same");
        run = 1'b1;
        for (int k = 0; k < 10; k++) tick(1'b0, "R6 same code no reload");
        run = 1'b0; mode_sel = 3'd6; tick(1'b0, "R6 reserved");
        run = 1'b1;
        for (int k = 0; k < 10; k++) tick(1'b0, "R6 reserved code ignored");

        // select PRBS15 for the insertion tests
        run = 1'b0; mode_sel = 3'd1; tick(1'b0, "R6 select");
        run = 1'b1;
        tick(1'b0, "R7 pre");
        // R7: single insertion hits the word after the next
        insert_req = 1'b1; tick(1'b0, "R7 request word clean");
        insert_req = 1'b0; tick(1'b1, "R7 corrupted word");
        chk_cnt(1, "R10 count after one");
        tick(1'b0, "R7 only one word"); tick(1'b0, "R7 only one word");
        chk_cnt(1, "R7 count stable");

        // R9: back-to-back requests merge
        insert_req = 1'b1; tick(1'b0, "R9 first");
        tick(1'b1, "R9 merged word");
        insert_req = 1'b0; tick(1'b0, "R9 no second"); tick(1'b0, "R9 no second");
        chk_cnt(2, "R9 count");

        // R8: request while stopped is ignored
        run = 1'b0; insert_req = 1'b1; tick(1'b0, "R8 stopped");
        insert_req = 1'b0; tick(1'b0, "R8 stopped");
        run = 1'b1;
        for (int k = 0; k < 3; k++) tick(1'b0, "R8 no corruption after stop");
        chk_cnt(2, "R8 count stopped");

        // R8: pending request dropped by a stop
        insert_req = 1'b1; tick(1'b0, "R8 pending");
        run = 1'b0; insert_req = 1'b0; tick(1'b0, "R8 drop");
        run = 1'b1;
        tick(1'b0, "R8 dropped"); tick(1'b0, "R8 dropped");
        chk_cnt(2, "R8 count drop");

        // R11: clear
        clear_req = 1'b1; tick(1'b0, "R11 clear");
        clear_req = 1'b0;
        chk_cnt(0, "R11 cleared");

        // R10: saturation at 7
        for (int k = 1; k <= 9; k++) begin
            insert_req = 1'b1; tick(1'b0, "R10 request");
            insert_req = 1'b0; tick(1'b1, "R10 corrupted at saturation");
            chk_cnt((k < 7) ? k : 7, "R10 saturating count");
        end

        // R11: clear wins over a simultaneous increment
        insert_req = 1'b1; tick(1'b0, "R11 request");
        insert_req = 1'b0; clear_req = 1'b1; tick(1'b1, "R11 corrupted");
        clear_req = 1'b0;
        chk_cnt(0, "R11 clear priority");

        // R6: code change while running is ignored, then taken when stopped
        mode_sel = 3'd4;
        for (int k = 0; k < 5; k++) tick(1'b0, "R6 change while running");
        run = 1'b0; tick(1'b0, "R6 take");
        run = 1'b1;
        for (int k = 0; k < 10; k++) tick(1'b0, "R3 after reload");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule